// File: doc/BRIEF.md
# Segmented Address and Byte-Lane Unit

This block sits between an execution core and a 16-bit memory bus. It keeps four 16-bit segment base registers (extra, code, stack, data), an instruction pointer and a stack pointer. For each access request it picks the segment base and offset that the access kind calls for. It then forms a 20-bit physical address as base times sixteen plus offset, and runs the bus cycles needed to move the data.

Bytes are steered by address parity. An even byte uses the low lane and an odd byte uses the high lane. A word at an even address moves in one cycle. A word at an odd address is split into two byte cycles, and the read result is put back together in little-endian order. Pushes pre-decrement the stack pointer and pops post-increment it. Instruction fetches advance the instruction pointer by the size fetched.

Top module: `sa_bus_unit`

## Requirements
- R1: After reset, `busy`, `bus_cyc` and `done` are low, and all six registers (four segment bases, instruction pointer, stack pointer) hold zero.
- R2: The physical address is (segment << 4) + offset, computed modulo 2^20. Any carry beyond bit 19 is dropped.
- R3: A fetch (`req_kind`=0) uses the code segment and the instruction pointer as offset. The instruction pointer then advances by 2 for a word and by 1 for a byte.
- R4: A data access (`req_kind`=1) uses the data segment with `req_off`. When `req_ovr`=1, `req_seg` selects the segment instead: 0 extra, 1 code, 2 stack, 3 data.
- R5: A push (`req_kind`=2) first lowers the stack pointer by 2 (word) or 1 (byte). It then writes at stack segment : new stack pointer.
- R6: A pop (`req_kind`=3) reads at stack segment : current stack pointer. The stack pointer then rises by 2 (word) or 1 (byte).
- R7: A byte access at an even address uses `bus_be`=01 and data bits 7:0. At an odd address it uses `bus_be`=10 and bits 15:8. On a byte write the unused lane is driven to zero. A byte read returns the byte zero-extended in `rd_data`.
- R8: A word at an even address takes one bus cycle with `bus_be`=11. Its low byte is on bits 7:0 and its high byte on bits 15:8.
- R9: A word at odd address A takes two cycles. The first is at A with `bus_be`=10, carrying the low byte on bits 15:8. The second is at A+1 with `bus_be`=01, carrying the high byte on bits 7:0. A read returns {second byte, first byte}.
- R10: A request accepted at clock edge k drives the first bus cycle in the clock period after k. `busy` stays high through every bus cycle of the access. `done` pulses for exactly one cycle after the last bus cycle. A request presented while `busy` is high is ignored.
- R11: The load port writes `ld_val` into the register chosen by `ld_sel`: 0 extra, 1 code, 2 stack, 3 data, 4 instruction pointer, 5 stack pointer. A load is ignored while `busy` is high and in the cycle a request is accepted.
- R12: The second cycle of a split word at physical address FFFFF goes to address 00000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, accepted when not busy |
| req_kind | input | 2 | 0 fetch, 1 data, 2 push, 3 pop |
| req_word | input | 1 | 1 word, 0 byte |
| req_write | input | 1 | Write direction for data accesses |
| req_ovr | input | 1 | Use `req_seg` instead of the data segment |
| req_seg | input | 2 | Segment choice for overridden data accesses |
| req_off | input | 16 | Effective offset for data accesses |
| req_wdata | input | 16 | Write data, low byte in bits 7:0 |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 3 | Register chosen for load |
| ld_val | input | 16 | Load value |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Assembled read result |
| bus_cyc | output | 1 | Bus cycle active this clock |
| bus_wr | output | 1 | Bus cycle is a write |
| bus_addr | output | 20 | Physical byte address |
| bus_be | output | 2 | Lane enables, bit 0 low lane |
| bus_wdata | output | 16 | Steered write data |
| bus_rdata | input | 16 | Read data, sampled at the end of each bus cycle |

## Verification
The hardest situation to reach is one where register state and the split sequencing interact. Examples are a push of a word while the stack pointer is odd, a split whose second cycle wraps past the top of the 20-bit space, and a load or new request arriving inside the two-cycle split window. The stimulus loads an odd stack pointer and a segment base of FFFF so that these splits happen. In the cycle after acceptance it raises the load strobe and another request together. Later accesses then show, through their bus addresses, whether the stack pointer or the instruction pointer was wrongly changed.

// File: rtl/sa_pkg.sv
package sa_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_DATA  = 2'd1,
      ACC_PUSH  = 2'd2,
      ACC_POP   = 2'd3
   } acc_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FIRST  = 2'd1,
      ST_SECOND = 2'd2
   } bus_st_e;

   // register file slots; the first four follow the override segment code
   localparam int unsigned REG_EXTRA = 0;
   localparam int unsigned REG_CODE  = 1;
   localparam int unsigned REG_STACK = 2;
   localparam int unsigned REG_DATA  = 3;
   localparam int unsigned REG_IP    = 4;
   localparam int unsigned REG_SP    = 5;
   localparam int unsigned NUM_REGS  = 6;
   localparam int unsigned SEL_W     = $clog2(NUM_REGS);

endpackage

// File: rtl/sa_addr_gen.sv
module sa_addr_gen #(
   parameter int REG_W = 16,
   parameter int SHIFT = 4,
   parameter int PA_W  = REG_W + SHIFT
) (
   input  logic [REG_W-1:0] seg_i,
   input  logic [REG_W-1:0] off_i,
   output logic [PA_W-1:0]  phys_o
);
   localparam int SH_W = REG_W + SHIFT;

   logic [SH_W-1:0] seg_sh;

   assign seg_sh = {seg_i, {SHIFT{1'b0}}};
   // sum kept at PA_W bits: any carry out of the top bit is dropped
   assign phys_o = PA_W'(seg_sh) + PA_W'(off_i);

   if (SH_W > PA_W) begin : g_bad_pa
      $error("sa_addr_gen: PA_W narrower than shifted segment");
   end
endmodule

// File: rtl/sa_seg_regs.sv
module sa_seg_regs
   import sa_pkg::*;
#(
   parameter int REG_W = 16
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               ld_en_i,
   input  logic [SEL_W-1:0]                   ld_sel_i,
   input  logic [REG_W-1:0]                   ld_val_i,
   input  logic                               ip_we_i,
   input  logic [REG_W-1:0]                   ip_val_i,
   input  logic                               sp_we_i,
   input  logic [REG_W-1:0]                   sp_val_i,
   output logic [NUM_REGS-1:0][REG_W-1:0]     regs_o
);
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic upd_we;
      logic [REG_W-1:0] upd_val;

      if (i == REG_IP) begin : g_ip
         assign upd_we  = ip_we_i;
         assign upd_val = ip_val_i;
      end else if (i == REG_SP) begin : g_sp
         assign upd_we  = sp_we_i;
         assign upd_val = sp_val_i;
      end else begin : g_seg
         assign upd_we  = 1'b0;
         assign upd_val = '0;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            regs_o[i] <= '0;
         end else if (upd_we) begin
            regs_o[i] <= upd_val;
         end else if (ld_en_i && (ld_sel_i == SEL_W'(i))) begin
            regs_o[i] <= ld_val_i;
         end
      end
   end
endmodule

// File: rtl/sa_lane_steer.sv
module sa_lane_steer #(
   parameter int DATA_W = 16
) (
   input  logic                  word_i,
   input  logic                  odd_i,
   input  logic                  phase2_i,
   input  logic [DATA_W-1:0]     wdata_i,
   input  logic [DATA_W-1:0]     rdata_i,
   input  logic [DATA_W-1:0]     rd_hold_i,
   output logic [DATA_W/8-1:0]   be_o,
   output logic [DATA_W-1:0]     wdata_o,
   output logic [DATA_W-1:0]     rd_next_o
);
   localparam int LANES = DATA_W / 8;

   logic full;
   logic sel_lane;
   logic src_byte;

   assign full = word_i && !odd_i;

   always_comb begin
      if (!word_i) begin
         sel_lane = odd_i;
         src_byte = 1'b0;
      end else if (!phase2_i) begin
         sel_lane = 1'b1;
         src_byte = 1'b0;
      end else begin
         sel_lane = 1'b0;
         src_byte = 1'b1;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic hit;
      assign hit = (sel_lane == 1'(l));
      assign be_o[l] = full || hit;
      assign wdata_o[l*8 +: 8] = full ? wdata_i[l*8 +: 8] :
                                 (hit ? wdata_i[src_byte*8 +: 8] : 8'h00);
   end

   always_comb begin
      rd_next_o = rd_hold_i;
      if (full) begin
         rd_next_o = rdata_i;
      end else if (!word_i) begin
         rd_next_o = {8'h00, odd_i ? rdata_i[15:8] : rdata_i[7:0]};
      end else if (!phase2_i) begin
         rd_next_o[7:0] = rdata_i[15:8];
      end else begin
         rd_next_o[15:8] = rdata_i[7:0];
      end
   end

   if (LANES != 2) begin : g_bad_lanes
      $error("sa_lane_steer: only a two-lane bus is supported");
   end
endmodule

// File: rtl/sa_bus_unit.sv
module sa_bus_unit
   import sa_pkg::*;
#(
   parameter int REG_W  = 16,
   parameter int SHIFT  = 4,
   parameter int DATA_W = 16,
   localparam int PA_W  = REG_W + SHIFT,
   localparam int BE_W  = DATA_W / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [1:0]         req_kind,
   input  logic               req_word,
   input  logic               req_write,
   input  logic               req_ovr,
   input  logic [1:0]         req_seg,
   input  logic [REG_W-1:0]   req_off,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic               ld_en,
   input  logic [2:0]         ld_sel,
   input  logic [REG_W-1:0]   ld_val,
   output logic               busy,
   output logic               done,
   output logic [DATA_W-1:0]  rd_data,
   output logic               bus_cyc,
   output logic               bus_wr,
   output logic [PA_W-1:0]    bus_addr,
   output logic [BE_W-1:0]    bus_be,
   output logic [DATA_W-1:0]  bus_wdata,
   input  logic [DATA_W-1:0]  bus_rdata
);
   if (DATA_W != 16) begin : g_bad_dw
      $error("sa_bus_unit: DATA_W must be 16");
   end
   if (SHIFT < 1) begin : g_bad_shift
      $error("sa_bus_unit: SHIFT must be at least 1");
   end

   acc_kind_e kind;
   bus_st_e   st_q;

   logic [NUM_REGS-1:0][REG_W-1:0] regs;
   logic [REG_W-1:0]  step;
   logic [REG_W-1:0]  seg_v;
   logic [REG_W-1:0]  off_v;
   logic              wr_v;
   logic              ip_we;
   logic              sp_we;
   logic [REG_W-1:0]  ip_nv;
   logic [REG_W-1:0]  sp_nv;
   logic              acc;
   logic              ld_ok;
   logic [PA_W-1:0]   phys;

   logic [PA_W-1:0]   a_q;
   logic              word_q;
   logic              odd_q;
   logic              wr_q;
   logic [DATA_W-1:0] wd_q;
   logic [DATA_W-1:0] rd_q;
   logic              done_q;
   logic [DATA_W-1:0] steer_wd;
   logic [DATA_W-1:0] rd_next;

   assign kind  = acc_kind_e'(req_kind);
   assign acc   = req_valid && (st_q == ST_IDLE);
   assign ld_ok = ld_en && !acc && (st_q == ST_IDLE);
   assign step  = req_word ? REG_W'(2) : REG_W'(1);
   assign ip_nv = regs[REG_IP] + step;

   always_comb begin
      seg_v = regs[REG_DATA];
      off_v = req_off;
      wr_v  = req_write;
      ip_we = 1'b0;
      sp_we = 1'b0;
      sp_nv = regs[REG_SP];
      case (kind)
         ACC_FETCH: begin
            seg_v = regs[REG_CODE];
            off_v = regs[REG_IP];
            wr_v  = 1'b0;
            ip_we = acc;
         end
         ACC_DATA: begin
            if (req_ovr) seg_v = regs[req_seg];
         end
         ACC_PUSH: begin
            seg_v = regs[REG_STACK];
            sp_nv = regs[REG_SP] - step;
            off_v = sp_nv;
            wr_v  = 1'b1;
            sp_we = acc;
         end
         ACC_POP: begin
            seg_v = regs[REG_STACK];
            off_v = regs[REG_SP];
            sp_nv = regs[REG_SP] + step;
            wr_v  = 1'b0;
            sp_we = acc;
         end
         default: ;
      endcase
   end

   sa_seg_regs #(.REG_W(REG_W)) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en_i  (ld_ok),
      .ld_sel_i (ld_sel),
      .ld_val_i (ld_val),
      .ip_we_i  (ip_we),
      .ip_val_i (ip_nv),
      .sp_we_i  (sp_we),
      .sp_val_i (sp_nv),
      .regs_o   (regs)
   );

   sa_addr_gen #(.REG_W(REG_W), .SHIFT(SHIFT), .PA_W(PA_W)) agen_i (
      .seg_i  (seg_v),
      .off_i  (off_v),
      .phys_o (phys)
   );

   sa_lane_steer #(.DATA_W(DATA_W)) steer_i (
      .word_i    (word_q),
      .odd_i     (odd_q),
      .phase2_i  (st_q == ST_SECOND),
      .wdata_i   (wd_q),
      .rdata_i   (bus_rdata),
      .rd_hold_i (rd_q),
      .be_o      (bus_be),
      .wdata_o   (steer_wd),
      .rd_next_o (rd_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         a_q    <= '0;
         word_q <= 1'b0;
         odd_q  <= 1'b0;
         wr_q   <= 1'b0;
         wd_q   <= '0;
         rd_q   <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (acc) begin
                  st_q   <= ST_FIRST;
                  a_q    <= phys;
                  word_q <= req_word;
                  odd_q  <= phys[0];
                  wr_q   <= wr_v;
                  wd_q   <= req_wdata;
                  rd_q   <= '0;
               end
            end
            ST_FIRST: begin
               if (!wr_q) rd_q <= rd_next;
               if (word_q && odd_q) begin
                  st_q <= ST_SECOND;
               end else begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
            ST_SECOND: begin
               if (!wr_q) rd_q <= rd_next;
               st_q   <= ST_IDLE;
               done_q <= 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st_q != ST_IDLE);
   assign bus_cyc   = (st_q == ST_FIRST) || (st_q == ST_SECOND);
   assign bus_wr    = wr_q && bus_cyc;
   assign bus_addr  = (st_q == ST_SECOND) ? (a_q + PA_W'(1)) : a_q;
   assign bus_wdata = wr_q ? steer_wd : '0;
   assign rd_data   = rd_q;
   assign done      = done_q;
endmodule

// File: rtl/sa_bus_unit_chk.sv
module sa_bus_unit_chk #(
   parameter int PA_W = 20
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            done,
   input logic            bus_cyc,
   input logic            bus_wr,
   input logic [PA_W-1:0] bus_addr,
   input logic [1:0]      bus_be,
   input logic [15:0]     bus_wdata
);
   // R10
   done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_after_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(bus_cyc) && !bus_cyc));

   // R10
   cyc_under_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cyc |-> busy);

   // R7
   lane_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_cyc |-> (bus_be != 2'b00));

   // R8
   full_word_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && bus_be == 2'b11) |-> !bus_addr[0]);

   // R9 and R12
   split_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && $past(bus_cyc)) |->
         (bus_be == 2'b01 && $past(bus_be) == 2'b10 &&
          bus_addr == $past(bus_addr) + PA_W'(1)));

   // R7
   unused_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && bus_wr && bus_be == 2'b01) |-> (bus_wdata[15:8] == 8'h00));
endmodule

bind sa_bus_unit sa_bus_unit_chk #(.PA_W(REG_W + SHIFT)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .bus_cyc   (bus_cyc),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_be    (bus_be),
   .bus_wdata (bus_wdata)
);

// File: tb/sa_bus_unit_tb_top.sv
module sa_bus_unit_tb_top;
   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst_n;
   logic        req_valid, req_word, req_write, req_ovr, ld_en;
   logic [1:0]  req_kind, req_seg;
   logic [15:0] req_off, req_wdata, ld_val;
   logic [2:0]  ld_sel;
   logic        busy, done, bus_cyc, bus_wr;
   logic [15:0] rd_data, bus_wdata, bus_rdata;
   logic [19:0] bus_addr;
   logic [1:0]  bus_be;

   sa_bus_unit dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_word(req_word), .req_write(req_write), .req_ovr(req_ovr),
      .req_seg(req_seg), .req_off(req_off), .req_wdata(req_wdata),
      .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val), .busy(busy),
      .done(done), .rd_data(rd_data), .bus_cyc(bus_cyc), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata)
   );

   int    n_tests = 0;
   int    n_fails = 0;
   string cur_rq = "R1";

   logic [7:0]  mem    [0:4095];
   logic [7:0]  shadow [0:4095];
   logic [38:0] exp_q  [$];
   logic [15:0] m_seg  [0:3];
   logic [15:0] m_ip, m_sp;

   assign bus_rdata = {mem[{bus_addr[11:1], 1'b1}], mem[{bus_addr[11:1], 1'b0}]};

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4096; i++) mem[i] <= 8'(i * 37 + 11);
      end else if (bus_cyc && bus_wr) begin
         if (bus_be[0]) mem[{bus_addr[11:1], 1'b0}] <= bus_wdata[7:0];
         if (bus_be[1]) mem[{bus_addr[11:1], 1'b1}] <= bus_wdata[15:8];
      end
   end

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      n_tests++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, expv);
      end
   endtask

   // monitor: pops one expected bus cycle per observed cycle
   always @(negedge clk) begin
      logic [38:0] item;
      if (rst_n && bus_cyc) begin
         if (exp_q.size() == 0) begin
            check(1'b0, cur_rq, "unexpected bus cycle", {12'h0, bus_addr}, 32'h0);
         end else begin
            item = exp_q.pop_front();
            check(bus_addr == item[38:19], cur_rq, "bus address", {12'h0, bus_addr}, {12'h0, item[38:19]});
            check(bus_be == item[18:17], cur_rq, "byte enables", {30'h0, bus_be}, {30'h0, item[18:17]});
            check(bus_wr == item[16], cur_rq, "direction", {31'h0, bus_wr}, {31'h0, item[16]});
            if (item[16])
               check(bus_wdata == item[15:0], cur_rq, "write lanes", {16'h0, bus_wdata}, {16'h0, item[15:0]});
         end
      end
   end

   function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
      return {s, 4'h0} + {4'h0, o};
   endfunction

   // mode 0 plain, 1 load with the request, 2 load and request while busy
   task automatic access(input logic [1:0] kind, input bit word, input bit wr,
                         input bit ovr, input logic [1:0] sel, input logic [15:0] off,
                         input logic [15:0] wd, input int mode, input string rq);
      logic [15:0] s, o, step, exp_rd;
      logic [19:0] a, a2;
      bit w, seen;
      int ncyc;
      cur_rq = rq;
      step = word ? 16'd2 : 16'd1;
      s = 16'h0; o = 16'h0;
      case (kind)
         2'd0: begin s = m_seg[1]; o = m_ip; m_ip = m_ip + step; end
         2'd1: begin s = ovr ? m_seg[sel] : m_seg[3]; o = off; end
         2'd2: begin m_sp = m_sp - step; s = m_seg[2]; o = m_sp; end
         default: begin s = m_seg[2]; o = m_sp; m_sp = m_sp + step; end
      endcase
      w = (kind == 2'd2) || (kind == 2'd1 && wr);
      a = pa(s, o);
      a2 = a + 20'd1;
      if (!word) begin
         ncyc = 1;
         exp_q.push_back({a, a[0] ? 2'b10 : 2'b01, w,
                          a[0] ? {wd[7:0], 8'h00} : {8'h00, wd[7:0]}});
      end else if (!a[0]) begin
         ncyc = 1;
         exp_q.push_back({a, 2'b11, w, wd});
      end else begin
         ncyc = 2;
         exp_q.push_back({a, 2'b10, w, {wd[7:0], 8'h00}});
         exp_q.push_back({a2, 2'b01, w, {8'h00, wd[15:8]}});
      end
      exp_rd = word ? {shadow[a2[11:0]], shadow[a[11:0]]} : {8'h00, shadow[a[11:0]]};
      if (w) begin
         shadow[a[11:0]] = wd[7:0];
         if (word) shadow[a2[11:0]] = wd[15:8];
      end
      req_valid = 1'b1; req_kind = kind; req_word = word; req_write = wr;
      req_ovr = ovr; req_seg = sel; req_off = off; req_wdata = wd;
      ld_en = (mode == 1); ld_sel = 3'd5; ld_val = 16'h5555;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; ld_en = 1'b0;
      if (mode == 2) begin
         req_valid = 1'b1; req_kind = 2'd0; req_word = 1'b1;
         ld_en = 1'b1; ld_sel = 3'd5; ld_val = 16'h5555;
      end
      seen = 1'b0;
      for (int k = 1; k <= 6; k++) begin
         if (k > 1) @(negedge clk);
         if (k == 2) begin req_valid = 1'b0; ld_en = 1'b0; end
         if (done) begin
            seen = 1'b1;
            check(k == ncyc + 1, rq, "done timing", 32'(k), 32'(ncyc + 1));
            check(!busy, rq, "busy after done", {31'h0, busy}, 32'h0);
            break;
         end
      end
      req_valid = 1'b0; ld_en = 1'b0;
      check(seen, rq, "done seen", {31'h0, seen}, 32'h1);
      if (!w) check(rd_data == exp_rd, rq, "read data", {16'h0, rd_data}, {16'h0, exp_rd});
      check(exp_q.size() == 0, rq, "missing bus cycles", 32'(exp_q.size()), 32'h0);
   endtask

   task automatic load(input logic [2:0] sel, input logic [15:0] v);
      ld_en = 1'b1; ld_sel = sel; ld_val = v;
      @(posedge clk);
      @(negedge clk);
      ld_en = 1'b0;
      if (sel < 3'd4) m_seg[sel[1:0]] = v;
      else if (sel == 3'd4) m_ip = v;
      else m_sp = v;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++; n_fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4096; i++) shadow[i] = 8'(i * 37 + 11);
      for (int i = 0; i < 4; i++) m_seg[i] = 16'h0;
      m_ip = 16'h0; m_sp = 16'h0;
      rst_n = 1'b0; req_valid = 1'b0; req_kind = 2'd0; req_word = 1'b0;
      req_write = 1'b0; req_ovr = 1'b0; req_seg = 2'd0; req_off = 16'h0;
      req_wdata = 16'h0; ld_en = 1'b0; ld_sel = 3'd0; ld_val = 16'h0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!busy, "R1", "busy", {31'h0, busy}, 32'h0);
      check(!bus_cyc, "R1", "bus_cyc", {31'h0, bus_cyc}, 32'h0);
      check(!done, "R1", "done", {31'h0, done}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 zero registers: fetch at 00000, pop at 00000
      access(2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 0, "R1");
      access(2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 0, "R1");
      // R11 loads
      load(3'd0, 16'h4000); load(3'd1, 16'h1234); load(3'd2, 16'h3000);
      load(3'd3, 16'h2000); load(3'd4, 16'h0010); load(3'd5, 16'h0100);
      // R2 R3 fetches word, byte even, byte odd, word
      access(2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 0, "R3");
      access(2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 0, "R3");
      access(2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 0, "R7");
      access(2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 0, "R2");
      // R4 R7 data bytes in default segment
      access(2'd1, 1'b0, 1'b1, 1'b0, 2'd0, 16'h0040, 16'h77A5, 0, "R7");
      access(2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0040, 16'h0, 0, "R4");
      access(2'd1, 1'b0, 1'b1, 1'b0, 2'd0, 16'h0045, 16'h883C, 0, "R7");
      access(2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0045, 16'h0, 0, "R7");
      // R8 even word
      access(2'd1, 1'b1, 1'b1, 1'b0, 2'd0, 16'h0050, 16'hBEEF, 0, "R8");
      access(2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0050, 16'h0, 0, "R8");
      // R9 odd word split
      access(2'd1, 1'b1, 1'b1, 1'b0, 2'd0, 16'h0061, 16'h1234, 0, "R9");
      access(2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0061, 16'h0, 0, "R9");
      access(2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0060, 16'h0, 0, "R9");
      // R4 overrides: extra, stack, code
      access(2'd1, 1'b0, 1'b1, 1'b1, 2'd0, 16'h0003, 16'h00C7, 0, "R4");
      access(2'd1, 1'b1, 1'b0, 1'b1, 2'd2, 16'h0020, 16'h0, 0, "R4");
      access(2'd1, 1'b1, 1'b0, 1'b1, 2'd1, 16'h0033, 16'h0, 0, "R4");
      // R5 R6 stack sequence
      access(2'd2, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0, 16'hCAFE, 0, "R5");
      access(2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0042, 0, "R5");
      access(2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 0, "R6");
      access(2'd3, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 0, "R6");
      load(3'd5, 16'h0101);
      access(2'd2, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0, 16'hA1B2, 0, "R5");
      access(2'd3, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 0, "R6");
      // R10 R11 load and request during busy, load at acceptance
      access(2'd1, 1'b1, 1'b1, 1'b0, 2'd0, 16'h0071, 16'h5A6B, 2, "R10");
      access(2'd3, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 1, "R11");
      access(2'd3, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 2, "R11");
      access(2'd0, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 0, "R10");
      // R12 and R2 wrap cases
      load(3'd3, 16'hFFFF);
      access(2'd1, 1'b1, 1'b1, 1'b0, 2'd0, 16'h000F, 16'hD00D, 0, "R12");
      access(2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 16'h000F, 16'h0, 0, "R12");
      access(2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0100, 16'h0, 0, "R2");
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fails);
      $finish;
   end
endmodule